// File: doc/BRIEF.md
# Windowed Register File with Spill and Fill

This block is a 32-entry architectural register file backed by a larger circular physical array. Numbers 0 to 7 name eight global registers that every window shares. Numbers 8 to 31 form a 24-register window that moves through the array under control of a current-window pointer. Each window has three groups of eight: an outgoing group (8..15), a private group (16..23) and an incoming group (24..31). The outgoing group of window w is the same storage as the incoming group of window w+1, so a caller and its callee exchange values without copying. The block has two combinational read ports and one write port.

A SAVE command advances the pointer by one and a RESTORE command moves it back by one, with wrap-around across eight windows. The block keeps a count of resident windows. A SAVE when seven windows are resident must first free the oldest one, so the block streams that window's sixteen registers out, one per cycle, to an external sequencer that pushes them onto a memory stack. A RESTORE when only the current window is resident must first bring in the window below, so the block takes sixteen words from the sequencer, one per cycle. During either transfer the block is busy and takes no new command. When the transfer ends it completes the pending move and pulses a done signal.

Top module: `winreg_file`

## Requirements
- R1: After a synchronous reset the pointer (curWin) is 0, busy, spillReq, fillReq and xferDone are 0, every register reads 0, and exactly one window is resident.
- R2: Register number 0 always reads 0, and a write to it has no effect.
- R3: Registers 1..7 are global: a value written there reads back unchanged in every window.
- R4: In window w, numbers 24+i name the same register as number 8+i in window w-1, and numbers 16+i are private to each window.
- R5: With no transfer needed, a SAVE seen while idle makes curWin equal (w+1) mod 8 in the next cycle, and a RESTORE makes it (w-1) mod 8.
- R6: A SAVE while seven windows are resident starts a spill in the next cycle: for 16 cycles spillReq is 1, xferWin gives the oldest resident window (curWin-6 mod 8), xferIdx counts 0 to 15, and spillData gives that window's private register i when xferIdx is i (0..7) and its incoming register i-8 when xferIdx is i (8..15).
- R7: A RESTORE while one window is resident starts a fill in the next cycle: for 16 cycles fillReq is 1, xferWin is curWin-1 mod 8, and the fillData word presented while xferIdx is i is stored into that window with the same index mapping as R6.
- R8: In the cycle after the last transfer beat, xferDone is 1 for that one cycle, busy is 0, and curWin has moved by one in the direction of the stalled command.
- R9: SAVE and RESTORE commands presented while busy is 1 have no effect on curWin.
- R10: If SAVE and RESTORE are both asserted while idle, only the SAVE is performed.
- R11: A write takes effect at the clock edge, and a read of the same register in the next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rdAddrA | input | 5 | Read port A register number |
| rdDataA | output | 32 | Read port A data (combinational) |
| rdAddrB | input | 5 | Read port B register number |
| rdDataB | output | 32 | Read port B data (combinational) |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Write register number |
| wrData | input | 32 | Write data |
| saveCmd | input | 1 | Advance window |
| restoreCmd | input | 1 | Step window back |
| curWin | output | 3 | Current window pointer |
| busy | output | 1 | Spill or fill in progress |
| spillReq | output | 1 | Spill beat valid |
| fillReq | output | 1 | Fill beat valid |
| xferWin | output | 3 | Window being spilled or filled |
| xferIdx | output | 4 | Beat index within the transfer |
| spillData | output | 32 | Outgoing word for the current spill beat |
| fillData | input | 32 | Incoming word for the current fill beat |
| xferDone | output | 1 | One-cycle pulse after a transfer completes |

## Verification
If the pointer is wrong, the next read of any windowed register returns the wrong value, and curWin shows the error in the cycle after the command. If the resident count is wrong, the block spills or fills one command too early or too late. That shows at once as a spillReq or fillReq rising, or failing to rise, in the cycle after a SAVE or RESTORE. A wrong spill address shows on spillData within one beat. A wrong fill address shows at the first later read of the refilled window, or of the live window it overwrote.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPILL = 2'd1,
    ST_FILL  = 2'd2
  } wrf_state_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic beat;  // a transfer beat happens this cycle
    logic fill;  // the beat writes the array (fill) rather than reading it
  } wrf_strobe_t;

endpackage

// File: rtl/wrf_map.sv
// Translates an architectural register number into a physical array index.
module wrf_map #(
  parameter  int NWIN  = 8,
  parameter  int GRP   = 8,
  localparam int AW    = $clog2(4 * GRP),
  localparam int CW    = $clog2(NWIN),
  localparam int NPHYS = GRP + 2 * GRP * NWIN,
  localparam int PW    = $clog2(NPHYS)
) (
  input  logic [AW-1:0] arch,
  input  logic [CW-1:0] cwp,
  output logic [PW-1:0] phys
);
  localparam int GB = $clog2(GRP);

  logic [1:0]    grpSel;
  logic [GB-1:0] offset;
  logic [CW-1:0] nextWin;

  assign grpSel  = arch[AW-1:GB];
  assign offset  = arch[GB-1:0];
  assign nextWin = (cwp == CW'(NWIN - 1)) ? '0 : cwp + CW'(1);

  // block layout per window: private group first, then incoming group
  always_comb begin
    case (grpSel)
      2'd0:    phys = PW'(int'(offset));
      2'd1:    phys = PW'(GRP + 2 * GRP * int'(nextWin) + GRP + int'(offset));
      2'd2:    phys = PW'(GRP + 2 * GRP * int'(cwp) + int'(offset));
      default: phys = PW'(GRP + 2 * GRP * int'(cwp) + GRP + int'(offset));
    endcase
  end

endmodule

// File: rtl/wrf_ctrl.sv
// Window pointer, resident count and transfer sequencing.
module wrf_ctrl
  import wrf_pkg::*;
#(
  parameter  int NWIN = 8,
  parameter  int GRP  = 8,
  localparam int CW   = $clog2(NWIN),
  localparam int IW   = $clog2(2 * GRP),
  localparam int RW   = $clog2(NWIN) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          saveCmd,
  input  logic          restoreCmd,
  output logic [CW-1:0] cwp,
  output logic [CW-1:0] xferWin,
  output logic [IW-1:0] xferIdx,
  output wrf_strobe_t   strobe,
  output logic          busy,
  output logic          spillReq,
  output logic          fillReq,
  output logic          xferDone
);
  localparam logic [IW-1:0] LAST = IW'(2 * GRP - 1);
  localparam logic [RW-1:0] FULL = RW'(NWIN - 1);
  localparam logic [RW-1:0] ONE  = RW'(1);

  wrf_state_t    state, stateNxt;
  logic [CW-1:0] cwpQ, cwpNxt, winQ, winNxt;
  logic [RW-1:0] resQ, resNxt;
  logic [IW-1:0] idxQ, idxNxt;
  logic          doneQ, doneNxt;

  function automatic logic [CW-1:0] wrapAdd(input logic [CW-1:0] w, input int n);
    return CW'((int'(w) + 2 * NWIN + n) % NWIN);
  endfunction

  always_comb begin
    stateNxt = state;
    cwpNxt   = cwpQ;
    winNxt   = winQ;
    resNxt   = resQ;
    idxNxt   = idxQ;
    doneNxt  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (saveCmd) begin
          if (resQ == FULL) begin
            stateNxt = ST_SPILL;
            winNxt   = wrapAdd(cwpQ, 1 - int'(resQ));
            idxNxt   = '0;
          end else begin
            cwpNxt = wrapAdd(cwpQ, 1);
            resNxt = resQ + ONE;
          end
        end else if (restoreCmd) begin
          if (resQ == ONE) begin
            stateNxt = ST_FILL;
            winNxt   = wrapAdd(cwpQ, -1);
            idxNxt   = '0;
          end else begin
            cwpNxt = wrapAdd(cwpQ, -1);
            resNxt = resQ - ONE;
          end
        end
      end
      default: begin
        idxNxt = idxQ + IW'(1);
        if (idxQ == LAST) begin
          stateNxt = ST_IDLE;
          doneNxt  = 1'b1;
          cwpNxt   = (state == ST_SPILL) ? wrapAdd(cwpQ, 1) : wrapAdd(cwpQ, -1);
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cwpQ  <= '0;
      winQ  <= '0;
      resQ  <= ONE;
      idxQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      state <= stateNxt;
      cwpQ  <= cwpNxt;
      winQ  <= winNxt;
      resQ  <= resNxt;
      idxQ  <= idxNxt;
      doneQ <= doneNxt;
    end
  end

  assign cwp         = cwpQ;
  assign xferWin     = winQ;
  assign xferIdx     = idxQ;
  assign busy        = (state != ST_IDLE);
  assign spillReq    = (state == ST_SPILL);
  assign fillReq     = (state == ST_FILL);
  assign xferDone    = doneQ;
  assign strobe.beat = busy;
  assign strobe.fill = fillReq;

  // R6 / R7: never both transfer kinds at once
  p_xfer_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(spillReq && fillReq));

  // R6: beats advance by one each cycle until the last
  p_beat_step_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && idxQ != LAST) |=> (busy && idxQ == IW'($past(idxQ) + IW'(1))));

  // R9: the pointer holds while a transfer is running
  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && idxQ != LAST) |=> $stable(cwpQ));

  // R8: the last beat is followed by the done pulse and idle
  p_done_after_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && idxQ == LAST) |=> (xferDone && !busy));

  // R8: done lasts a single cycle
  p_done_once_r8: assert property (@(posedge clk) disable iff (rst)
    xferDone |=> !xferDone);

  // R5: resident count stays between one and NWIN-1
  p_res_range_r5: assert property (@(posedge clk) disable iff (rst)
    (resQ >= ONE) && (resQ <= FULL));

endmodule

// File: rtl/wrf_dpath.sv
// Physical register array, read translation, write and transfer ports.
module wrf_dpath
  import wrf_pkg::*;
#(
  parameter  int DW    = 32,
  parameter  int NWIN  = 8,
  parameter  int GRP   = 8,
  localparam int AW    = $clog2(4 * GRP),
  localparam int CW    = $clog2(NWIN),
  localparam int IW    = $clog2(2 * GRP),
  localparam int NPHYS = GRP + 2 * GRP * NWIN,
  localparam int PW    = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cwp,
  input  logic [CW-1:0] xferWin,
  input  logic [IW-1:0] xferIdx,
  input  wrf_strobe_t   strobe,
  input  logic [AW-1:0] rdAddrA,
  input  logic [AW-1:0] rdAddrB,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] fillData,
  output logic [DW-1:0] rdDataA,
  output logic [DW-1:0] rdDataB,
  output logic [DW-1:0] spillData
);
  localparam int NRD = 2;

  logic [DW-1:0] regs [NPHYS];
  logic [AW-1:0] rAddr [NRD];
  logic [PW-1:0] rPhys [NRD];
  logic [DW-1:0] rData [NRD];
  logic [PW-1:0] wPhys;
  logic [PW-1:0] xPhys;
  logic [CW-1:0] nextWin;

  assign rAddr[0] = rdAddrA;
  assign rAddr[1] = rdAddrB;

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    wrf_map #(.NWIN(NWIN), .GRP(GRP)) u_map (
      .arch(rAddr[g]),
      .cwp (cwp),
      .phys(rPhys[g])
    );
    assign rData[g] = (rAddr[g] == '0) ? '0 : regs[rPhys[g]];
  end

  assign rdDataA = rData[0];
  assign rdDataB = rData[1];

  wrf_map #(.NWIN(NWIN), .GRP(GRP)) u_wmap (
    .arch(wrAddr),
    .cwp (cwp),
    .phys(wPhys)
  );

  // transfer beat i addresses word i of the window block
  assign xPhys     = PW'(GRP + 2 * GRP * int'(xferWin) + int'(xferIdx));
  assign spillData = regs[xPhys];
  assign nextWin   = (cwp == CW'(NWIN - 1)) ? '0 : cwp + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPHYS; i++) regs[i] <= '0;
    end else begin
      if (wrEn && wrAddr != '0) regs[wPhys] <= wrData;
      if (strobe.beat && strobe.fill) regs[xPhys] <= fillData;
    end
  end

  // R2: the zero register never picks up a value
  p_zero_hold_r2: assert property (@(posedge clk) disable iff (rst)
    regs[0] == '0);

  // R7: a fill never lands in the blocks the live window uses
  p_fill_apart_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe.beat && strobe.fill) |-> (xferWin != cwp && xferWin != nextWin));

endmodule

// File: rtl/winreg_file.sv
module winreg_file
  import wrf_pkg::*;
#(
  parameter  int DATA_W  = 32,
  parameter  int NUM_WIN = 8,
  parameter  int GRP_REGS = 8,
  localparam int AW = $clog2(4 * GRP_REGS),
  localparam int CW = $clog2(NUM_WIN),
  localparam int IW = $clog2(2 * GRP_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [AW-1:0]     rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              saveCmd,
  input  logic              restoreCmd,
  output logic [CW-1:0]     curWin,
  output logic              busy,
  output logic              spillReq,
  output logic              fillReq,
  output logic [CW-1:0]     xferWin,
  output logic [IW-1:0]     xferIdx,
  output logic [DATA_W-1:0] spillData,
  input  logic [DATA_W-1:0] fillData,
  output logic              xferDone
);
  wrf_strobe_t strobe;

  wrf_ctrl #(.NWIN(NUM_WIN), .GRP(GRP_REGS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .saveCmd   (saveCmd),
    .restoreCmd(restoreCmd),
    .cwp       (curWin),
    .xferWin   (xferWin),
    .xferIdx   (xferIdx),
    .strobe    (strobe),
    .busy      (busy),
    .spillReq  (spillReq),
    .fillReq   (fillReq),
    .xferDone  (xferDone)
  );

  wrf_dpath #(.DW(DATA_W), .NWIN(NUM_WIN), .GRP(GRP_REGS)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .cwp      (curWin),
    .xferWin  (xferWin),
    .xferIdx  (xferIdx),
    .strobe   (strobe),
    .rdAddrA  (rdAddrA),
    .rdAddrB  (rdAddrB),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .fillData (fillData),
    .rdDataA  (rdDataA),
    .rdDataB  (rdDataB),
    .spillData(spillData)
  );

endmodule

// File: tb/sim_winreg_file.sv
module sim_winreg_file;
  localparam int CLK_P = 10;
  localparam int NW    = 8;
  localparam int BASE  = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0, spillData, fillData = '0;
  logic        wrEn = 1'b0, saveCmd = 1'b0, restoreCmd = 1'b0;
  logic [2:0]  curWin, xferWin;
  logic [3:0]  xferIdx;
  logic        busy, spillReq, fillReq, xferDone;

  int nChecks = 0;
  int nFail   = 0;

  // architectural model: frames by call depth; outs of d are ins of d+1
  logic [31:0] mGlb [8];
  logic [31:0] mLoc [256][8];
  logic [31:0] mIns [256][8];
  bit          kLoc [256][8];
  bit          kIns [256][8];
  int          depth;
  int          res;

  winreg_file u0 (
    .clk(clk), .rst(rst),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .saveCmd(saveCmd), .restoreCmd(restoreCmd),
    .curWin(curWin), .busy(busy), .spillReq(spillReq), .fillReq(fillReq),
    .xferWin(xferWin), .xferIdx(xferIdx),
    .spillData(spillData), .fillData(fillData), .xferDone(xferDone)
  );

  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [32:0] mRead(input int a);
    if (a == 0) return {1'b1, 32'h0};
    if (a < 8)  return {1'b1, mGlb[a]};
    if (a < 16) return {kIns[depth + 1][a - 8], mIns[depth + 1][a - 8]};
    if (a < 24) return {kLoc[depth][a - 16], mLoc[depth][a - 16]};
    return {kIns[depth][a - 24], mIns[depth][a - 24]};
  endfunction

  task automatic mWrite(input int a, input logic [31:0] v);
    if (a == 0) return;
    if (a < 8) mGlb[a] = v;
    else if (a < 16) begin mIns[depth + 1][a - 8] = v; kIns[depth + 1][a - 8] = 1'b1; end
    else if (a < 24) begin mLoc[depth][a - 16] = v; kLoc[depth][a - 16] = 1'b1; end
    else begin mIns[depth][a - 24] = v; kIns[depth][a - 24] = 1'b1; end
  endtask

  function automatic string tagOf(input int a);
    if (a == 0) return "R2";
    if (a < 8)  return "R3";
    return "R4";
  endfunction

  task automatic forgetNew();
    for (int i = 0; i < 8; i++) begin
      kLoc[depth][i]     = 1'b0;
      kIns[depth + 1][i] = 1'b0;
    end
  endtask

  // one cycle: optional write plus two reads checked against the model
  task automatic cycleRW(input bit doWr, input logic [4:0] wa, input logic [31:0] wd,
                         input logic [4:0] ra, input logic [4:0] rb);
    logic [32:0] ea, eb;
    @(negedge clk);
    saveCmd = 1'b0; restoreCmd = 1'b0;
    rdAddrA = ra; rdAddrB = rb; wrEn = doWr; wrAddr = wa; wrData = wd;
    #1;
    ea = mRead(int'(ra));
    eb = mRead(int'(rb));
    if (ea[32]) chk({tagOf(int'(ra)), "/R11 portA"}, rdDataA, ea[31:0]);
    if (eb[32]) chk({tagOf(int'(rb)), "/R11 portB"}, rdDataB, eb[31:0]);
    if (doWr) mWrite(int'(wa), wd);
  endtask

  task automatic cmd(input bit s, input bit r);
    string mvTag;
    int od;
    mvTag = (s && r) ? "R10" : "R5";
    @(negedge clk);
    wrEn = 1'b0; saveCmd = s; restoreCmd = r;
    @(negedge clk);
    saveCmd = 1'b0; restoreCmd = 1'b0;
    #1;
    if (s && res == NW - 1) begin
      od = depth - (res - 1);
      for (int j = 0; j < 16; j++) begin
        chk("R6 spillReq", 32'(spillReq), 32'd1);
        chk("R6 xferWin", 32'(xferWin), 32'(od % NW));
        chk("R6 xferIdx", 32'(xferIdx), 32'(j));
        if (j < 8) begin
          if (kLoc[od][j]) chk("R6 spillData", spillData, mLoc[od][j]);
        end else begin
          if (kIns[od][j - 8]) chk("R6 spillData", spillData, mIns[od][j - 8]);
        end
        if (j == 5) begin saveCmd = 1'b1; restoreCmd = 1'b1; end
        if (j == 6) begin saveCmd = 1'b0; restoreCmd = 1'b0; end
        @(negedge clk);
        #1;
      end
      depth++;
      forgetNew();
      chk("R8 xferDone", 32'(xferDone), 32'd1);
      chk("R8 busy", 32'(busy), 32'd0);
      chk("R9/R8 curWin", 32'(curWin), 32'(depth % NW));
    end else if (s) begin
      depth++; res++;
      forgetNew();
      chk({mvTag, " save curWin"}, 32'(curWin), 32'(depth % NW));
      chk({mvTag, " no spill"}, 32'(spillReq), 32'd0);
    end else if (r && res == 1) begin
      od = depth - 1;
      for (int j = 0; j < 16; j++) begin
        logic [31:0] v;
        v = $urandom;
        if (j < 8) begin mLoc[od][j] = v; kLoc[od][j] = 1'b1; end
        else begin mIns[od][j - 8] = v; kIns[od][j - 8] = 1'b1; end
        fillData = v;
        chk("R7 fillReq", 32'(fillReq), 32'd1);
        chk("R7 xferWin", 32'(xferWin), 32'(od % NW));
        chk("R7 xferIdx", 32'(xferIdx), 32'(j));
        if (j == 5) begin restoreCmd = 1'b1; end
        if (j == 6) begin restoreCmd = 1'b0; end
        @(negedge clk);
        #1;
      end
      depth--;
      chk("R8 xferDone", 32'(xferDone), 32'd1);
      chk("R8 busy", 32'(busy), 32'd0);
      chk("R9/R8 curWin", 32'(curWin), 32'(depth % NW));
    end else if (r) begin
      depth--; res--;
      chk("R5 restore curWin", 32'(curWin), 32'(depth % NW));
      chk("R5 no fill", 32'(fillReq), 32'd0);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    depth = BASE;
    res   = 1;
    for (int i = 0; i < 8; i++) mGlb[i] = '0;
    for (int f = 0; f < 256; f++)
      for (int i = 0; i < 8; i++) begin
        mLoc[f][i] = '0; mIns[f][i] = '0;
        kLoc[f][i] = 1'b0; kIns[f][i] = 1'b0;
      end
    for (int i = 0; i < 8; i++) begin
      kLoc[BASE][i] = 1'b1; kIns[BASE][i] = 1'b1; kIns[BASE + 1][i] = 1'b1;
    end

    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk("R1 curWin", 32'(curWin), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 spillReq", 32'(spillReq), 32'd0);
    chk("R1 fillReq", 32'(fillReq), 32'd0);
    chk("R1 xferDone", 32'(xferDone), 32'd0);
    cycleRW(1'b0, 5'd0, 32'd0, 5'd20, 5'd27);

    // R2: write to zero register
    cycleRW(1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0);
    cycleRW(1'b0, 5'd0, 32'd0, 5'd0, 5'd0);

    // R3 / R4 / R11: globals, outs, locals
    cycleRW(1'b1, 5'd3, 32'hA5A5_0003, 5'd3, 5'd9);
    cycleRW(1'b1, 5'd9, 32'hB0B0_0009, 5'd3, 5'd9);
    cycleRW(1'b1, 5'd17, 32'hC0C0_0017, 5'd9, 5'd17);
    cycleRW(1'b0, 5'd0, 32'd0, 5'd17, 5'd3);
    cmd(1'b1, 1'b0);
    cycleRW(1'b1, 5'd17, 32'hD0D0_0017, 5'd3, 5'd25);
    cycleRW(1'b0, 5'd0, 32'd0, 5'd17, 5'd25);
    cmd(1'b0, 1'b1);
    cycleRW(1'b0, 5'd0, 32'd0, 5'd17, 5'd9);

    // R7: underflow fill from the single resident window
    cmd(1'b0, 1'b1);
    cycleRW(1'b0, 5'd0, 32'd0, 5'd16, 5'd31);
    cycleRW(1'b0, 5'd0, 32'd0, 5'd23, 5'd24);

    // R6 / R8 / R9: fill the array then overflow
    for (int k = 0; k < 6; k++) begin
      cmd(1'b1, 1'b0);
      cycleRW(1'b1, 5'(16 + k), $urandom, 5'(16 + k), 5'(8 + k));
    end
    cmd(1'b1, 1'b0);
    cycleRW(1'b0, 5'd0, 32'd0, 5'd24, 5'd26);

    // R10: both commands at once
    cmd(1'b1, 1'b1);
    cmd(1'b1, 1'b1);

    // constrained random mix
    for (int it = 0; it < 1500; it++) begin
      int pick;
      pick = int'($urandom % 10);
      if (depth > BASE + 100) pick = 7;
      if (depth < BASE - 100) pick = 6;
      if (pick <= 5)
        cycleRW(1'b1, 5'($urandom), $urandom, 5'($urandom), 5'($urandom));
      else if (pick == 6) cmd(1'b1, 1'b0);
      else if (pick == 7) cmd(1'b0, 1'b1);
      else if (pick == 8) cmd(1'b1, 1'b1);
      else cycleRW(1'b0, 5'd0, 32'd0, 5'($urandom), 5'($urandom));
    end

    cycleRW(1'b0, 5'd0, 32'd0, 5'd0, 5'd1);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule